// File: doc/BRIEF.md
# DMA Page Table Translator

This block turns a 32-bit device-side DMA address into a physical address. It does this by looking the address up in a flat, single-level page table that sits in system memory. Software locates the table with two configuration registers. The table-origin register gives the byte address of the first entry, and its most significant bit is ignored. The table-span register gives the table size in bytes.

Pages are a fixed 4 KiB. Every table entry is 8 bytes long. The first 32-bit word of an entry holds the physical frame, and the second word is never used.

A request arrives on a valid/ready port. The block splits the address into a page number and a 12-bit offset, then checks the page number against the number of whole entries in the span. For a page inside the table, it issues exactly one single-word read for the entry. It then returns the frame with the offset merged in. A page outside the table, or an entry read that reports an error, gives a fault response instead. The response is held until the requester accepts it.

Top module: `dma_xlate`

## Requirements
- R1: After reset, reqReady is 1 and rspValid and memRdValid are 0. The origin and span registers are both zero, so the first request faults without any memory read.
- R2: The page number is reqAddr >> 12, and it is in range only when it is below span >> 3. An out-of-range request never reads memory, and it responds with rspFault = 1 and rspPhys = 0.
- R3: The entry read address is (origin & 0x7FFFFFFF) + page*8, computed modulo 2^32. memRdValid and memRdAddr stay unchanged until memRdReady is seen.
- R4: A good translation returns rspPhys = {frame[31:12], reqAddr[11:0]} with rspFault = 0. Only the frame word at the entry address is read; the second word of the entry is never fetched.
- R5: An entry read answered with memRspErr = 1 responds with rspFault = 1 and rspPhys = 0.
- R6: A new request is taken only while idle (reqReady = 1). A pending response keeps rspValid, rspPhys and rspFault unchanged until rspReady is sampled high.
- R7: A cfgWrEn write loads cfgWrData into the origin register when cfgSel = 0 and into the span register when cfgSel = 1. A write made while a request is in flight has no effect on that request; it applies from the next accepted request on.
- R8: In the cycle after a request is accepted, exactly one of memRdValid (in range) or rspValid (out of range) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects the table origin, 1 selects the table span |
| cfgWrData | input | 32 | Configuration write value |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Block is idle and takes the request |
| reqAddr | input | 32 | Device DMA address to translate |
| rspValid | output | 1 | Translation result valid |
| rspReady | input | 1 | Requester accepts the result |
| rspPhys | output | 32 | Translated physical address, zero on fault |
| rspFault | output | 1 | Translation failed, no access permitted |
| memRdValid | output | 1 | Entry read request valid |
| memRdReady | input | 1 | Memory accepts the read request |
| memRdAddr | output | 32 | Byte address of the entry frame word |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Frame word returned by memory |
| memRspErr | input | 1 | Read failed |

## Verification
A corrupted page number or origin shows up at memRdAddr on the first cycle after acceptance, before any data returns. A wrong bounds decision is visible one cycle after acceptance: it shows as the wrong choice between memRdValid and rspValid, and as a change in the count of memory reads. A stale or prematurely updated configuration snapshot only becomes visible when one request is stalled across a register write. A lost offset or a mishandled error shows only in the final rspPhys/rspFault pair. For that reason, each vector checks both the fetch address and the result.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FETCH = 2'd2,
    ST_RESP  = 2'd3
  } xlateState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;    // latch request offset and entry address
    logic setFault;   // load a fault result
    logic takeFrame;  // load result from memory response
  } xlateStrobe_t;

endpackage

// File: rtl/dma_xlate_ctrl.sv
module dma_xlate_ctrl
  import dma_xlate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         inRange,
  input  logic         memRdReady,
  input  logic         memRspValid,
  input  logic         rspReady,
  output logic         reqReady,
  output logic         memRdValid,
  output logic         rspValid,
  output xlateStrobe_t strobe
);

  xlateState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          if (inRange) begin
            stateNext = ST_ISSUE;
          end else begin
            strobe.setFault = 1'b1;
            stateNext       = ST_RESP;
          end
        end
      end
      ST_ISSUE: if (memRdReady) stateNext = ST_FETCH;
      ST_FETCH: begin
        if (memRspValid) begin
          strobe.takeFrame = 1'b1;
          stateNext        = ST_RESP;
        end
      end
      ST_RESP:  if (rspReady) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady   = (state == ST_IDLE);
  assign memRdValid = (state == ST_ISSUE);
  assign rspValid   = (state == ST_RESP);

endmodule

// File: rtl/dma_xlate_dp.sv
module dma_xlate_dp
  import dma_xlate_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_BITS   = 12,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlateStrobe_t      strobe,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] memRspData,
  input  logic              memRspErr,
  output logic              inRange,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic [ADDR_W-1:0] rspPhys,
  output logic              rspFault
);

  localparam logic [ADDR_W-1:0] ORIGIN_MASK = {1'b0, {(ADDR_W-1){1'b1}}};
  localparam logic [ADDR_W-1:0] FRAME_MASK  = {{(ADDR_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};
  localparam int NUM_CFG = 2;

  logic [ADDR_W-1:0]    cfgReg [NUM_CFG];
  logic [ADDR_W-1:0]    pageNum;
  logic [ADDR_W-1:0]    entryCount;
  logic [ADDR_W-1:0]    entryAddrNext;
  logic [ADDR_W-1:0]    entryAddrReg;
  logic [PAGE_BITS-1:0] offsetReg;
  logic [ADDR_W-1:0]    physReg;
  logic                 faultReg;

  // configuration registers: index 0 = origin, 1 = span
  for (genvar g = 0; g < NUM_CFG; g++) begin : gCfg
    always_ff @(posedge clk) begin
      if (!rstN) cfgReg[g] <= '0;
      else if (cfgWrEn && (cfgSel == 1'(g))) cfgReg[g] <= cfgWrData;
    end
  end

  assign pageNum       = reqAddr >> PAGE_BITS;
  assign entryCount    = cfgReg[1] >> ENTRY_SHIFT;
  assign inRange       = (pageNum < entryCount);
  assign entryAddrNext = (cfgReg[0] & ORIGIN_MASK) + (pageNum << ENTRY_SHIFT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryAddrReg <= '0;
      offsetReg    <= '0;
    end else if (strobe.capture) begin
      entryAddrReg <= entryAddrNext;
      offsetReg    <= reqAddr[PAGE_BITS-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      physReg  <= '0;
      faultReg <= 1'b0;
    end else if (strobe.setFault) begin
      physReg  <= '0;
      faultReg <= 1'b1;
    end else if (strobe.takeFrame) begin
      if (memRspErr) begin
        physReg  <= '0;
        faultReg <= 1'b1;
      end else begin
        physReg  <= (memRspData & FRAME_MASK) | ADDR_W'(offsetReg);
        faultReg <= 1'b0;
      end
    end
  end

  assign memRdAddr = entryAddrReg;
  assign rspPhys   = physReg;
  assign rspFault  = faultReg;

endmodule

// File: rtl/dma_xlate.sv
module dma_xlate
  import dma_xlate_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_BITS   = 12,
  parameter int ENTRY_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [ADDR_W-1:0] rspPhys,
  output logic              rspFault,
  output logic              memRdValid,
  input  logic              memRdReady,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  input  logic              memRspErr
);

  xlateStrobe_t strobe;
  logic         inRange;

  dma_xlate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .inRange    (inRange),
    .memRdReady (memRdReady),
    .memRspValid(memRspValid),
    .rspReady   (rspReady),
    .reqReady   (reqReady),
    .memRdValid (memRdValid),
    .rspValid   (rspValid),
    .strobe     (strobe)
  );

  dma_xlate_dp #(
    .ADDR_W     (ADDR_W),
    .PAGE_BITS  (PAGE_BITS),
    .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cfgWrEn   (cfgWrEn),
    .cfgSel    (cfgSel),
    .cfgWrData (cfgWrData),
    .reqAddr   (reqAddr),
    .memRspData(memRspData),
    .memRspErr (memRspErr),
    .inRange   (inRange),
    .memRdAddr (memRdAddr),
    .rspPhys   (rspPhys),
    .rspFault  (rspFault)
  );

endmodule

// File: rtl/dma_xlate_chk.sv
module dma_xlate_chk #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic [PAGE_BITS-1:0] reqOffset,
  input logic                 rspValid,
  input logic                 rspReady,
  input logic [ADDR_W-1:0]    rspPhys,
  input logic                 rspFault,
  input logic                 memRdValid,
  input logic                 memRdReady,
  input logic [ADDR_W-1:0]    memRdAddr
);

  logic [PAGE_BITS-1:0] seenOffset;

  always_ff @(posedge clk) begin
    if (!rstN) seenOffset <= '0;
    else if (reqValid && reqReady) seenOffset <= reqOffset;
  end

  assert_rsp_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspPhys) && $stable(rspFault));

  assert_busy_no_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid || memRdValid) |-> !reqReady);

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid && !memRdReady |=> memRdValid && $stable(memRdAddr));

  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspFault |-> rspPhys == '0);

  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspFault |-> rspPhys[PAGE_BITS-1:0] == seenOffset);

  assert_one_path_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> $countones({memRdValid, rspValid}) == 1);

endmodule

bind dma_xlate dma_xlate_chk #(
  .ADDR_W   (ADDR_W),
  .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqOffset (reqAddr[PAGE_BITS-1:0]),
  .rspValid  (rspValid),
  .rspReady  (rspReady),
  .rspPhys   (rspPhys),
  .rspFault  (rspFault),
  .memRdValid(memRdValid),
  .memRdReady(memRdReady),
  .memRdAddr (memRdAddr)
);

// File: tb/dma_xlate_tb.sv
module dma_xlate_tb;

  localparam logic [31:0] ERR_ADDR = 32'h0000_0058;

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] expPhys;
    logic        expFault;
    logic        expRead;
    logic [31:0] expEntry;
  } vec_t;

  // origin 0x8000_0040 (top bit ignored), span 48 bytes = 6 entries
  localparam vec_t VECS [7] = '{
    '{32'h0000_0123, 32'h1000_0123, 1'b0, 1'b1, 32'h0000_0040},
    '{32'h0000_1FFF, 32'h1001_1FFF, 1'b0, 1'b1, 32'h0000_0048},
    '{32'h0000_2000, 32'h1002_2000, 1'b0, 1'b1, 32'h0000_0050},
    '{32'h0000_5ABC, 32'h1005_5ABC, 1'b0, 1'b1, 32'h0000_0068},
    '{32'h0000_6000, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000},
    '{32'hFFFF_F000, 32'h0000_0000, 1'b1, 1'b0, 32'h0000_0000},
    '{32'h0000_3456, 32'h0000_0000, 1'b1, 1'b1, 32'h0000_0058}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [31:0] rspPhys;
  logic        rspFault;
  logic        memRdValid;
  logic        memRdReady;
  logic [31:0] memRdAddr;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        memRspErr;
  logic        grantOn = 1'b1;

  logic [31:0] mem [64];
  int          rdCount;
  logic [31:0] lastRdAddr;
  int          nChecks = 0;
  int          nFail = 0;

  always #4 clk = ~clk;

  assign memRdReady = grantOn;

  dma_xlate u_dut (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspReady(rspReady), .rspPhys(rspPhys), .rspFault(rspFault),
    .memRdValid(memRdValid), .memRdReady(memRdReady), .memRdAddr(memRdAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .memRspErr(memRspErr)
  );

  // memory model: frames at word 16+2i, owner words hold filler
  initial begin
    for (int w = 0; w < 64; w++) mem[w] = 32'hDEAD_0000 | 32'(w);
    for (int i = 0; i < 8; i++) mem[16 + 2*i] = 32'h1000_0ABC + 32'(i) * 32'h0001_1000;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memRspValid <= 1'b0;
      memRspData  <= '0;
      memRspErr   <= 1'b0;
      rdCount     <= 0;
      lastRdAddr  <= '0;
    end else begin
      memRspValid <= memRdValid && memRdReady;
      if (memRdValid && memRdReady) begin
        rdCount    <= rdCount + 1;
        lastRdAddr <= memRdAddr;
        memRspData <= mem[memRdAddr[7:2]];
        memRspErr  <= (memRdAddr[31:8] != 0) || (memRdAddr == ERR_ADDR);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [31:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = val;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic sendReq(input logic [31:0] a);
    @(negedge clk);
    chk("R6 reqReady before request", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic getRsp(output logic [31:0] phys, output logic fault);
    int waitCnt = 0;
    while (!rspValid && waitCnt < 50) begin
      @(negedge clk);
      waitCnt++;
    end
    phys = rspPhys; fault = rspFault;
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] phys;
    logic        fault;
    int          rdBefore;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reqReady", 32'(reqReady), 32'd1);
    chk("R1 rspValid", 32'(rspValid), 32'd0);
    chk("R1 memRdValid", 32'(memRdValid), 32'd0);
    sendReq(32'h0000_0000);
    getRsp(phys, fault);
    chk("R1 fault with zero span", 32'(fault), 32'd1);
    chk("R1 no read after reset", 32'(rdCount), 32'd0);

    // R7 configuration, R3 origin top bit set
    cfgWrite(1'b0, 32'h8000_0040);
    cfgWrite(1'b1, 32'd48);

    foreach (VECS[k]) begin
      rdBefore = rdCount;
      sendReq(VECS[k].addr);
      // R8 path choice one cycle after accept
      chk("R8 memRdValid after accept", 32'(memRdValid), 32'(VECS[k].expRead));
      chk("R8 rspValid after accept", 32'(rspValid), 32'(!VECS[k].expRead));
      getRsp(phys, fault);
      chk("R4 R5 rspPhys", phys, VECS[k].expPhys);
      chk("R2 R5 rspFault", 32'(fault), 32'(VECS[k].expFault));
      chk("R2 read count", 32'(rdCount - rdBefore), 32'(VECS[k].expRead));
      if (VECS[k].expRead)
        chk("R3 R4 entry address", lastRdAddr, VECS[k].expEntry);
    end

    // R3 stalled read, R7 write during walk
    grantOn = 1'b0;
    sendReq(32'h0000_2010);
    repeat (3) @(negedge clk);
    chk("R3 read held", 32'(memRdValid), 32'd1);
    chk("R3 read address held", memRdAddr, 32'h0000_0050);
    chk("R6 busy no accept", 32'(reqReady), 32'd0);
    cfgWrite(1'b0, 32'h0000_0048);
    grantOn = 1'b1;
    getRsp(phys, fault);
    chk("R7 in-flight uses old origin", phys, 32'h1002_2010);
    sendReq(32'h0000_0777);
    getRsp(phys, fault);
    chk("R7 next uses new origin", phys, 32'h1001_1777);

    // R6 response hold
    sendReq(32'h0000_0005);
    while (!rspValid) @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R6 rspValid held", 32'(rspValid), 32'd1);
      chk("R6 rspPhys held", rspPhys, 32'h1001_1005);
      chk("R6 reqReady low while holding", 32'(reqReady), 32'd0);
    end
    getRsp(phys, fault);

    // R2 span not a multiple of 8: 47 -> 5 entries
    cfgWrite(1'b1, 32'd47);
    rdBefore = rdCount;
    sendReq(32'h0000_5000);
    getRsp(phys, fault);
    chk("R2 floor span faults page 5", 32'(fault), 32'd1);
    chk("R2 floor span no read", 32'(rdCount - rdBefore), 32'd0);
    sendReq(32'h0000_4000);
    getRsp(phys, fault);
    chk("R2 last page in range", phys, 32'h1005_5000);
    chk("R2 last page no fault", 32'(fault), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule